// File: doc/BRIEF.md
# I2C Target Transaction Engine

This block is the protocol half of a two-wire serial target. It oversamples the bus clock and data lines with the system clock and recognises start, repeated start and stop conditions. It then takes in an address byte and compares it with a fixed 7-bit device address. On a match it runs either a write (a register-index byte followed by any number of data bytes) or a read (data bytes sent out, most significant bit first, one after another). The only output toward the bus is an active-high enable that pulls the data line low. It is used for acknowledge bits and for zero bits of read data.

Behind the engine sits a register block, reached through a small port: a register index, a one-cycle write strobe with its data, a one-cycle read strobe, and two answers from the register block. Those answers are read data and an accept flag, and the engine samples both in the strobe cycle. The engine acknowledges a written byte only if the register block accepts it. It refuses its own address while the register block reports a nonvolatile write in progress, so a host can poll for the end of that write. The register index steps by one after every byte that is written or read. A read that starts with no index byte continues from the last accessed register plus one.

Top module: `i2c_target_engine`

## Requirements
- R1: After reset the pull-low enable is 0 and neither register strobe is active.
- R2: A transfer begins only on a start condition (data falling while clock is high). A stop condition (data rising while clock is high) returns the engine to idle, and clocked bytes that follow no start get no acknowledge.
- R3: The address byte is the 7-bit address 0101000 followed by a direction bit (1 = read, 0 = write), so the write byte is 0x50 and the read byte is 0x51. Any other address gets no acknowledge, and later bytes up to the next start or stop are neither acknowledged nor passed on.
- R4: While nv_busy is high, a matching address byte is not acknowledged.
- R5: In a write, the register-index byte is always acknowledged. Each data byte gives exactly one write strobe, carrying the current index and the byte, on the eighth bit.
- R6: The register index steps by one after each written byte, so consecutive data bytes go to consecutive registers.
- R7: A random read (write-mode address, index byte, repeated start, read-mode address) returns the register at that index, most significant bit first.
- R8: A master acknowledge (0) after a read byte makes the engine fetch and send the next register. A master no-acknowledge (1) makes it release the line and send nothing more until a start or stop.
- R9: A read-mode address given straight after a start, with no index byte, returns the register after the last one accessed (index 0 after reset).
- R10: The pull-low enable changes only while the synchronised clock is low. It is 0 during the master's acknowledge slot.
- R11: A start or stop in the middle of a data byte drops that byte: no write strobe is issued.
- R12: When the register block rejects a written byte, that byte is not acknowledged. The engine then ignores the rest of the transfer until a stop or start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull_en | output | 1 | 1 pulls the data line low; 0 releases it |
| nv_busy | input | 1 | Register block is busy with a nonvolatile write |
| reg_addr | output | REG_AW | Register index for the current access |
| reg_wr_stb | output | 1 | One-cycle write request |
| reg_wr_data | output | 8 | Byte to write, valid with reg_wr_stb |
| reg_rd_stb | output | 1 | One-cycle read request |
| reg_rd_data | input | 8 | Read data, sampled in the reg_rd_stb cycle |
| reg_ok | input | 1 | Register block accepts the written byte, sampled with reg_wr_stb |

## Verification
The checks that run every cycle are simple. The data-line enable may change only while the synchronised clock is low. A write strobe lasts one cycle and falls while the clock is high, at the eighth bit. A read fetch happens while the clock is low. A stop always leaves the engine idle and released. Everything that depends on byte content needs the bench's bus scenarios. That covers address matching and busy refusal, rejected bytes, index stepping, random and continued reads, the master's no-acknowledge, and the dropping of a byte cut short by a start or stop.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;

    // Byte-level protocol phases of the target engine
    typedef enum logic [3:0] {
        ST_IDLE,      // waiting for a start condition
        ST_ADDR,      // shifting in the device address byte
        ST_ADDR_ACK,  // acknowledge slot of the address byte
        ST_INDEX,     // shifting in the register index byte
        ST_INDEX_ACK, // acknowledge slot of the index byte
        ST_WDATA,     // shifting in a write data byte
        ST_WDATA_ACK, // acknowledge slot of a write data byte
        ST_RDATA,     // shifting out a read data byte
        ST_RACK,      // master acknowledge slot after a read byte
        ST_PARK       // ignoring the bus until start or stop
    } tgt_state_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
module i2c_tgt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;

    // Synchroniser chains: stage 0 samples the pad, the last stage feeds logic
    always_comb begin
        d = q;
        d.scl_sh[0] = scl_in;
        d.sda_sh[0] = sda_in;
        for (int i = 1; i < STAGES; i++) begin
            d.scl_sh[i] = q.scl_sh[i-1];
            d.sda_sh[i] = q.sda_sh[i-1];
        end
        d.scl_prev = q.scl_sh[LAST];
        d.sda_prev = q.sda_sh[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl_sh: '1, sda_sh: '1, scl_prev: 1'b1, sda_prev: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign scl_s     = q.scl_sh[LAST];
    assign sda_s     = q.sda_sh[LAST];
    assign scl_rise  =  scl_s & ~q.scl_prev;
    assign scl_fall  = ~scl_s &  q.scl_prev;
    // Bus conditions: data moves while clock stays high on both samples
    assign start_det = scl_s & q.scl_prev &  q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & q.scl_prev & ~q.sda_prev &  sda_s;

endmodule

// File: rtl/i2c_tgt_fsm.sv
`timescale 1ns/1ps
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h28,
    parameter int unsigned REG_AW   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_s,
    input  logic                sda_s,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic                nv_busy,
    output logic                pull_en,
    output logic [REG_AW-1:0]   reg_addr,
    output logic                reg_wr_stb,
    output logic [BYTE_W-1:0]   reg_wr_data,
    output logic                reg_rd_stb,
    input  logic [BYTE_W-1:0]   reg_rd_data,
    input  logic                reg_ok
);

    localparam int unsigned CNT_W    = $clog2(BYTE_W) + 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    typedef struct packed {
        tgt_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
        logic [REG_AW-1:0] idx;
        logic              rd_dir;
        logic              ack;
        logic              in_slot;
        logic              more;
        logic              pull;
    } fsm_t;

    fsm_t q, d;
    logic [BYTE_W-1:0] byte_in;
    logic              fetch;

    assign byte_in = {q.rx[BYTE_W-2:0], sda_s};

    always_comb begin
        d           = q;
        fetch       = 1'b0;
        reg_wr_stb  = 1'b0;
        reg_wr_data = byte_in;

        if (stop_det) begin
            d.st      = ST_IDLE;
            d.pull    = 1'b0;
            d.in_slot = 1'b0;
            d.more    = 1'b0;
        end else if (start_det) begin
            d.st      = ST_ADDR;
            d.cnt     = '0;
            d.pull    = 1'b0;
            d.in_slot = 1'b0;
            d.more    = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE, ST_PARK: ;

                ST_ADDR, ST_INDEX, ST_WDATA: begin
                    if (scl_rise) begin
                        d.rx  = byte_in;
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == LAST_BIT) begin
                            d.cnt = '0;
                            if (q.st == ST_ADDR) begin
                                d.rd_dir = byte_in[0];
                                d.ack    = (byte_in[BYTE_W-1:1] == DEV_ADDR) && !nv_busy;
                                d.st     = ST_ADDR_ACK;
                            end else if (q.st == ST_INDEX) begin
                                d.idx = REG_AW'(byte_in);
                                d.ack = 1'b1;
                                d.st  = ST_INDEX_ACK;
                            end else begin
                                reg_wr_stb = 1'b1;
                                d.ack      = reg_ok;
                                d.idx      = q.idx + 1'b1;
                                d.st       = ST_WDATA_ACK;
                            end
                        end
                    end
                end

                ST_ADDR_ACK, ST_INDEX_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        if (!q.in_slot) begin
                            d.in_slot = 1'b1;
                            d.pull    = q.ack;
                        end else begin
                            d.in_slot = 1'b0;
                            d.pull    = 1'b0;
                            d.cnt     = '0;
                            if (!q.ack) begin
                                d.st = ST_PARK;
                            end else if (q.st == ST_ADDR_ACK) begin
                                if (q.rd_dir) fetch = 1'b1;
                                else          d.st  = ST_INDEX;
                            end else begin
                                d.st = ST_WDATA;
                            end
                        end
                    end
                end

                ST_RDATA: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.cnt == ALL_BITS) begin
                            d.pull = 1'b0;
                            d.cnt  = '0;
                            d.st   = ST_RACK;
                        end else begin
                            d.tx   = {q.tx[BYTE_W-2:0], 1'b0};
                            d.pull = ~q.tx[BYTE_W-2];
                        end
                    end
                end

                ST_RACK: begin
                    if (scl_rise) begin
                        if (!sda_s) d.more = 1'b1;
                        else        d.st   = ST_PARK;
                    end else if (scl_fall && q.more) begin
                        d.more = 1'b0;
                        fetch  = 1'b1;
                    end
                end

                default: d.st = ST_IDLE;
            endcase
        end

        // Shared read fetch: sample the register, drive its MSB, step index
        if (fetch) begin
            d.tx   = reg_rd_data;
            d.pull = ~reg_rd_data[BYTE_W-1];
            d.idx  = q.idx + 1'b1;
            d.cnt  = '0;
            d.st   = ST_RDATA;
        end
    end

    assign reg_rd_stb = fetch;
    assign reg_addr   = q.idx;
    assign pull_en    = q.pull;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, rx: '0, tx: '0, idx: '0,
                   rd_dir: 1'b0, ack: 1'b0, in_slot: 1'b0, more: 1'b0, pull: 1'b0};
        end else begin
            q <= d;
        end
    end

    // R10: the data-line enable only moves while the clock is low
    p_pull_moves_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.pull) |-> !scl_s);

    // R5: a write request is a single-cycle pulse
    p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_stb |=> !reg_wr_stb);

    // R11: writes are committed only on a clock-high eighth-bit sample
    p_wr_clock_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_stb |-> scl_s);

    // R7: read fetches happen in the low phase so the bit is ready before the rise
    p_rd_clock_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_stb |-> !scl_s);

    // R2: a stop leaves the engine idle and the line released
    p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.st == ST_IDLE && !q.pull));

endmodule

// File: rtl/i2c_target_engine.sv
`timescale 1ns/1ps
module i2c_target_engine #(
    parameter logic [6:0]  DEV_ADDR    = 7'h28,
    parameter int unsigned REG_AW      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_en,
    input  logic              nv_busy,
    output logic [REG_AW-1:0] reg_addr,
    output logic              reg_wr_stb,
    output logic [7:0]        reg_wr_data,
    output logic              reg_rd_stb,
    input  logic [7:0]        reg_rd_data,
    input  logic              reg_ok
);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_tgt_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .REG_AW   (REG_AW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_s       (scl_s),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .nv_busy     (nv_busy),
        .pull_en     (sda_pull_en),
        .reg_addr    (reg_addr),
        .reg_wr_stb  (reg_wr_stb),
        .reg_wr_data (reg_wr_data),
        .reg_rd_stb  (reg_rd_stb),
        .reg_rd_data (reg_rd_data),
        .reg_ok      (reg_ok)
    );

endmodule

// File: tb/i2c_target_engine_test.sv
`timescale 1ns/1ps
module i2c_target_engine_test;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       nv_busy = 1'b0;
    logic       sda_pull_en;
    logic [7:0] reg_addr;
    logic       reg_wr_stb;
    logic [7:0] reg_wr_data;
    logic       reg_rd_stb;
    logic [7:0] reg_rd_data;
    logic       reg_ok;
    logic       sda_line;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull_en;

    i2c_target_engine uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_m),
        .sda_in      (sda_line),
        .sda_pull_en (sda_pull_en),
        .nv_busy     (nv_busy),
        .reg_addr    (reg_addr),
        .reg_wr_stb  (reg_wr_stb),
        .reg_wr_data (reg_wr_data),
        .reg_rd_stb  (reg_rd_stb),
        .reg_rd_data (reg_rd_data),
        .reg_ok      (reg_ok)
    );

    // Register block model: 16 registers, indices 0x10 and up rejected
    logic [7:0] mem [16];
    assign reg_ok      = (reg_addr < 8'h10);
    assign reg_rd_data = mem[reg_addr[3:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 8'h40 + 8'(i);
        end else if (reg_wr_stb && reg_ok) begin
            mem[reg_addr[3:0]] <= reg_wr_data;
        end
    end

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    logic pull_seen;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard of expected write requests
    typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_item_t;
    wr_item_t exp_q[$];

    task automatic expect_wr(input logic [7:0] a, input logic [7:0] d);
        exp_q.push_back('{a: a, d: d});
    endtask

    always @(negedge clk) begin
        if (rst_n && reg_wr_stb) begin
            if (exp_q.size() == 0) begin
                nchk++;
                nfail++;
                $display("FAIL R11 unexpected write actual=%h:%h expected=none", reg_addr, reg_wr_data);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                chk("R5 write index", reg_addr, e.a);
                chk("R6 write data", reg_wr_data, e.d);
            end
        end
    end

    task automatic qw(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One bus bit; entered and left with the clock low
    task automatic bit_cyc(input logic b, output logic seen);
        qw(Q);
        sda_m = b;
        qw(Q);
        scl_m = 1'b1;
        qw(Q);
        seen = sda_line;
        pull_seen = sda_pull_en;
        qw(Q);
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        qw(Q);
        sda_m = 1'b1;
        qw(Q);
        scl_m = 1'b1;
        qw(2*Q);
        sda_m = 1'b0;
        qw(2*Q);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        qw(Q);
        sda_m = 1'b0;
        qw(Q);
        scl_m = 1'b1;
        qw(2*Q);
        sda_m = 1'b1;
        qw(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cyc(b[i], s);
        bit_cyc(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cyc(1'b1, s);
            b[i] = s;
        end
        bit_cyc(~m_ack, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic       a;
        logic [7:0] r;
        logic [7:0] unused_bits;
        logic       s;

        qw(5);
        rst_n = 1'b1;
        qw(5);
        // R1: reset state
        chk("R1 pull", {7'd0, sda_pull_en}, 8'd0);
        chk("R1 strobes", {6'd0, reg_wr_stb, reg_rd_stb}, 8'd0);

        // R2: a byte clocked with no start is ignored
        scl_m = 1'b0;
        send_byte(8'h50, a);
        chk("R2 no start no ack", {7'd0, a}, 8'd0);
        bus_stop();

        // R3/R5/R6: two-byte write from index 2
        bus_start();
        send_byte(8'h50, a); chk("R3 write address ack", {7'd0, a}, 8'd1);
        send_byte(8'h02, a); chk("R5 index ack", {7'd0, a}, 8'd1);
        expect_wr(8'h02, 8'hA5);
        send_byte(8'hA5, a); chk("R5 data ack", {7'd0, a}, 8'd1);
        expect_wr(8'h03, 8'h3C);
        send_byte(8'h3C, a); chk("R6 second data ack", {7'd0, a}, 8'd1);
        bus_stop();

        // R7/R8/R10: random read of two bytes, then clocks after the NACK
        bus_start();
        send_byte(8'h50, a);
        send_byte(8'h02, a);
        bus_start();
        send_byte(8'h51, a); chk("R3 read address ack", {7'd0, a}, 8'd1);
        recv_byte(1'b1, r); chk("R7 first read byte", r, 8'hA5);
        chk("R10 released in master ack slot", {7'd0, pull_seen}, 8'd0);
        recv_byte(1'b0, r); chk("R8 incremented read byte", r, 8'h3C);
        chk("R10 released in master nack slot", {7'd0, pull_seen}, 8'd0);
        recv_byte(1'b0, r); chk("R8 silent after nack", r, 8'hFF);
        bus_stop();

        // R9: reads with no index continue from last access plus one
        bus_start();
        send_byte(8'h51, a);
        recv_byte(1'b0, r); chk("R9 continued read", r, 8'h44);
        bus_stop();
        bus_start();
        send_byte(8'h51, a);
        recv_byte(1'b0, r); chk("R9 continued read again", r, 8'h45);
        bus_stop();

        // R4: busy refuses the address, then recovers
        nv_busy = 1'b1;
        bus_start();
        send_byte(8'h50, a); chk("R4 busy nack", {7'd0, a}, 8'd0);
        bus_stop();
        nv_busy = 1'b0;
        bus_start();
        send_byte(8'h50, a); chk("R4 ack after busy", {7'd0, a}, 8'd1);
        bus_stop();

        // R3: wrong address, later bytes ignored
        bus_start();
        send_byte(8'h52, a); chk("R3 wrong address nack", {7'd0, a}, 8'd0);
        send_byte(8'h07, a); chk("R3 byte after wrong address", {7'd0, a}, 8'd0);
        bus_stop();

        // R12: rejected byte is NACKed and the rest ignored
        bus_start();
        send_byte(8'h50, a);
        send_byte(8'h20, a);
        expect_wr(8'h20, 8'h77);
        send_byte(8'h77, a); chk("R12 reject nack", {7'd0, a}, 8'd0);
        send_byte(8'h11, a); chk("R12 ignored after reject", {7'd0, a}, 8'd0);
        bus_stop();

        // R11: stop in the middle of a data byte
        bus_start();
        send_byte(8'h50, a);
        send_byte(8'h06, a);
        for (int i = 0; i < 4; i++) bit_cyc(1'b1, s);
        bus_stop();
        bus_start();
        send_byte(8'h50, a);
        send_byte(8'h06, a);
        bus_start();
        send_byte(8'h51, a);
        recv_byte(1'b0, r); chk("R11 stop drops byte", r, 8'h46);
        bus_stop();

        // R11: repeated start in the middle of a data byte, then a full write
        bus_start();
        send_byte(8'h50, a);
        send_byte(8'h07, a);
        for (int i = 0; i < 3; i++) bit_cyc(1'b0, s);
        bus_start();
        send_byte(8'h50, a); chk("R11 address after restart", {7'd0, a}, 8'd1);
        send_byte(8'h07, a);
        expect_wr(8'h07, 8'h9E);
        send_byte(8'h9E, a); chk("R5 write after restart", {7'd0, a}, 8'd1);
        bus_stop();
        bus_start();
        send_byte(8'h50, a);
        send_byte(8'h07, a);
        bus_start();
        send_byte(8'h51, a);
        recv_byte(1'b0, r); chk("R7 read back", r, 8'h9E);
        bus_stop();

        qw(20);
        unused_bits = 8'(exp_q.size());
        chk("R5 all expected writes seen", unused_bits, 8'd0);
        chk("R1 idle release", {7'd0, sda_pull_en}, 8'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule